// File: doc/BRIEF.md
# Three-Wire Half-Duplex Serial Link Monitor

This block watches a three-wire, half-duplex serial link with a separate chip select, without driving any of it. The four link pins (select, serial clock, data into the target, data out of the target) are brought into the system clock domain through a two-stage synchronizer. Edges are then found by comparing each synchronized sample with the one from the previous system clock.

Every select window is sorted into one of two kinds, using the data-in level at the first rising serial clock edge. A high level there marks a bit transfer, and that first bit is the start bit. The monitor then streams one record per bit, holding the data-in value sampled on the rising clock edge and the data-out value sampled on the falling edge. Otherwise the window is a status check: the data-out level is reported as ready (high) or busy (low) while the window is open, and that level is held after the window closes. Records are emitted on a single-cycle strobe with no backpressure. Each window ends with a one-cycle done pulse that carries a saturating count of the bits emitted in that window.

Top module: `mw_monitor`

## Requirements
- R1: While reset (synchronous, active low) is asserted, every output is 0. After release, the monitor waits for a rising edge on the select pin.
- R2: A window opens on a rising edge of the select pin and closes when select returns low. Opening a window clears both error flags and the bit count.
- R3: Data-in is captured when the serial clock rises, and data-out is captured when it falls. Every record carries both captured values, on `bit_si` and `bit_so`.
- R4: If data-in is 1 at the first rising serial clock edge of a window, the window is a bit transfer. Its first record has `bit_is_start`=1 and every later record has `bit_is_start`=0.
- R5: A bit's record is emitted when the next rising serial clock edge arrives. The last bit's record is emitted when select falls while the serial clock is low. `window_done` is high for exactly one cycle per window, and in a transfer window it is high in the same cycle as the last record.
- R6: If select falls while the serial clock is high, the unfinished last bit of a transfer is discarded and no record is emitted for it.
- R7: A window with no rising serial clock edge, or with data-in 0 at the first rising edge, is a status check. `status_valid` is 1 from the opening of a window until the window is classified as a transfer. During a status check, `status_ready` follows the data-out level (1 = ready, 0 = busy). Both outputs hold their values after the window closes, until the next window opens.
- R8: `err_no_start_bit` is set when the first rising serial clock edge of a window sees data-in at 0.
- R9: If the serial clock is high when select rises, `err_sk_high_at_start` is set and the clock is treated as low. The falling edge that ends this initial high phase is not a bit edge, and the bits that follow decode normally.
- R10: `bit_count` counts the records emitted in the current window and is valid while `window_done` is high. It saturates at 2^CNT_W-1 and never wraps.
- R11: If the serial clock and select fall in the same sample, the data-out value from that sample is captured into the last record, which is emitted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_in | input | 1 | Link select, active high, asynchronous |
| sk_in | input | 1 | Link serial clock, asynchronous |
| si_in | input | 1 | Data into the target, asynchronous |
| so_in | input | 1 | Data out of the target, asynchronous |
| bit_valid | output | 1 | One-cycle strobe marking a bit record |
| bit_si | output | 1 | Data-in value of the record |
| bit_so | output | 1 | Data-out value of the record |
| bit_is_start | output | 1 | Record is the start bit |
| window_done | output | 1 | One-cycle pulse at the end of a window |
| bit_count | output | CNT_W | Saturating count of records in the window |
| status_valid | output | 1 | Window is (still) treated as a status check |
| status_ready | output | 1 | Status check level: 1 ready, 0 busy |
| err_sk_high_at_start | output | 1 | Serial clock was high when select rose |
| err_no_start_bit | output | 1 | First rising clock edge saw data-in low |

## Verification
Two events can land in the same cycle: emitting the last record and closing the window. The most demanding form of this is R11, where the serial clock and select fall together, so data-out must be captured and emitted in one cycle. The bench provokes it by changing data-out to the complement of its previous value at the exact moment both clock and select drop. It then checks that the final record holds the new value and that the record strobe and the done pulse were sampled high in the same cycle. A related case lets select fall while the clock is still high, and the bench confirms that exactly one record fewer appears.

// File: rtl/mw_pkg.sv
// Package: shared types for the serial link monitor.
// Assumes: pin vector order below is used by the synchronizer and core.
package mw_pkg;
    // Decoder phase within and between select windows.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for select to rise
        ST_ARMED = 2'd1,   // window open, no rising clock edge yet
        ST_XFER  = 2'd2,   // bit transfer in progress
        ST_STAT  = 2'd3    // status check in progress
    } mw_state_e;

    // Bit positions in the synchronized pin vector.
    localparam int PIN_SO = 0;
    localparam int PIN_SI = 1;
    localparam int PIN_SK = 2;
    localparam int PIN_CS = 3;
    localparam int NPINS  = 4;
endpackage

// File: rtl/mw_sync.sv
// Module: multi-bit flop-chain synchronizer.
// Does: moves W independent asynchronous levels into the clk domain.
// Assumes: each bit is a level that may be sampled independently.
module mw_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: one synchronizer stage, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= (s == 0) ? d_in : stg[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign d_out = stg[STAGES-1];
endmodule

// File: rtl/mw_edge.sv
// Module: edge detector over W synchronized levels.
// Does: compares each sample with the one a system clock earlier.
// Assumes: inputs are already synchronous to clk.
module mw_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    // Purpose: hold the previous sample of every level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/mw_core.sv
// Module: window classifier and bit record generator.
// Does: sorts each select window into transfer or status check,
//       captures data-in on rising and data-out on falling clock,
//       emits one record per bit and a done pulse with a bit count.
// Assumes: levels and edges are synchronous; select/clock edges are
//          one system clock wide.
module mw_core
    import mw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_rise,
    input  logic             cs_fall,
    input  logic             sk_lvl,
    input  logic             sk_rise,
    input  logic             sk_fall,
    input  logic             si_lvl,
    input  logic             so_lvl,
    output logic             bit_valid,
    output logic             bit_si,
    output logic             bit_so,
    output logic             bit_is_start,
    output logic             window_done,
    output logic [CNT_W-1:0] bit_count,
    output logic             status_valid,
    output logic             status_ready,
    output logic             err_sk_high_at_start,
    output logic             err_no_start_bit
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    mw_state_e state;
    logic      sk_phase;     // tracked clock phase, forced low at window start
    logic      pend_si;
    logic      pend_so;
    logic      pend_start;
    logic      fall_ok;
    logic      so_last;

    assign fall_ok = sk_fall & sk_phase;
    assign so_last = fall_ok ? so_lvl : pend_so;

    // Purpose: window state machine, capture and record output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state                <= ST_IDLE;
            sk_phase             <= 1'b0;
            pend_si              <= 1'b0;
            pend_so              <= 1'b0;
            pend_start           <= 1'b0;
            bit_valid            <= 1'b0;
            bit_si               <= 1'b0;
            bit_so               <= 1'b0;
            bit_is_start         <= 1'b0;
            window_done          <= 1'b0;
            bit_count            <= '0;
            status_valid         <= 1'b0;
            status_ready         <= 1'b0;
            err_sk_high_at_start <= 1'b0;
            err_no_start_bit     <= 1'b0;
        end else begin
            bit_valid   <= 1'b0;
            window_done <= 1'b0;
            if (state != ST_IDLE) begin
                if (sk_rise)      sk_phase <= 1'b1;
                else if (fall_ok) sk_phase <= 1'b0;
            end
            case (state)
                ST_IDLE: begin
                    if (cs_rise) begin
                        state                <= ST_ARMED;
                        sk_phase             <= 1'b0;
                        bit_count            <= '0;
                        bit_is_start         <= 1'b0;
                        status_valid         <= 1'b1;
                        status_ready         <= so_lvl;
                        err_sk_high_at_start <= sk_lvl;
                        err_no_start_bit     <= 1'b0;
                    end
                end
                ST_ARMED: begin
                    status_ready <= so_lvl;
                    if (cs_fall) begin
                        window_done <= 1'b1;
                        state       <= ST_IDLE;
                    end else if (sk_rise) begin
                        if (si_lvl) begin
                            state        <= ST_XFER;
                            status_valid <= 1'b0;
                            pend_si      <= 1'b1;
                            pend_so      <= 1'b0;
                            pend_start   <= 1'b1;
                        end else begin
                            state            <= ST_STAT;
                            err_no_start_bit <= 1'b1;
                        end
                    end
                end
                ST_STAT: begin
                    status_ready <= so_lvl;
                    if (cs_fall) begin
                        window_done <= 1'b1;
                        state       <= ST_IDLE;
                    end
                end
                ST_XFER: begin
                    if (cs_fall) begin
                        if (!sk_lvl) begin
                            bit_valid    <= 1'b1;
                            bit_si       <= pend_si;
                            bit_so       <= so_last;
                            bit_is_start <= pend_start;
                            if (bit_count != CNT_MAX) bit_count <= bit_count + 1'b1;
                        end
                        window_done <= 1'b1;
                        state       <= ST_IDLE;
                    end else if (sk_rise) begin
                        bit_valid    <= 1'b1;
                        bit_si       <= pend_si;
                        bit_so       <= pend_so;
                        bit_is_start <= pend_start;
                        if (bit_count != CNT_MAX) bit_count <= bit_count + 1'b1;
                        pend_si      <= si_lvl;
                        pend_so      <= 1'b0;
                        pend_start   <= 1'b0;
                    end else if (fall_ok) begin
                        pend_so <= so_lvl;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mw_monitor.sv
// Module: top of the serial link monitor.
// Does: synchronizes the four link pins, finds select and clock edges,
//       and hands them to the window decoder.
// Assumes: system clock is several times faster than the serial clock.
module mw_monitor
    import mw_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_in,
    input  logic             sk_in,
    input  logic             si_in,
    input  logic             so_in,
    output logic             bit_valid,
    output logic             bit_si,
    output logic             bit_so,
    output logic             bit_is_start,
    output logic             window_done,
    output logic [CNT_W-1:0] bit_count,
    output logic             status_valid,
    output logic             status_ready,
    output logic             err_sk_high_at_start,
    output logic             err_no_start_bit
);
    logic [NPINS-1:0] pins_raw;
    logic [NPINS-1:0] pins_s;
    logic [1:0]       ck_rise;
    logic [1:0]       ck_fall;

    always_comb begin
        pins_raw         = '0;
        pins_raw[PIN_CS] = cs_in;
        pins_raw[PIN_SK] = sk_in;
        pins_raw[PIN_SI] = si_in;
        pins_raw[PIN_SO] = so_in;
    end

    mw_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pins_raw),
        .d_out (pins_s)
    );

    // Edge bit 1 is select, bit 0 is serial clock.
    mw_edge #(.W(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({pins_s[PIN_CS], pins_s[PIN_SK]}),
        .rise  (ck_rise),
        .fall  (ck_fall)
    );

    mw_core #(.CNT_W(CNT_W)) u_core (
        .clk                  (clk),
        .rst_n                (rst_n),
        .cs_rise              (ck_rise[1]),
        .cs_fall              (ck_fall[1]),
        .sk_lvl               (pins_s[PIN_SK]),
        .sk_rise              (ck_rise[0]),
        .sk_fall              (ck_fall[0]),
        .si_lvl               (pins_s[PIN_SI]),
        .so_lvl               (pins_s[PIN_SO]),
        .bit_valid            (bit_valid),
        .bit_si               (bit_si),
        .bit_so               (bit_so),
        .bit_is_start         (bit_is_start),
        .window_done          (window_done),
        .bit_count            (bit_count),
        .status_valid         (status_valid),
        .status_ready         (status_ready),
        .err_sk_high_at_start (err_sk_high_at_start),
        .err_no_start_bit     (err_no_start_bit)
    );
endmodule

// File: rtl/mw_monitor_chk.sv
// Module: property checker for the serial link monitor, bound to the top.
// Assumes: connected to the top-level outputs only.
module mw_monitor_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_valid,
    input logic             bit_si,
    input logic             bit_is_start,
    input logic             window_done,
    input logic [CNT_W-1:0] bit_count,
    input logic             status_valid,
    input logic             err_no_start_bit
);
    // R4: a start-bit record always carries data-in 1.
    a_r4_start_is_one: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && bit_is_start) |-> bit_si);

    // R5: the done pulse lasts a single cycle.
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        window_done |=> !window_done);

    // R7: records appear only once the window is no longer a status check.
    a_r7_no_record_in_status: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> !status_valid);

    // R8: a missing start bit makes the window a status check.
    a_r8_nostart_is_status: assert property (@(posedge clk) disable iff (!rst_n)
        err_no_start_bit |-> status_valid);

    // R10: the count never wraps: it only grows or is cleared to zero.
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_count != '0) |=> (bit_count >= $past(bit_count)) || (bit_count == '0));

    // R10: the count changes only alongside a record or a clear to zero.
    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && bit_count != '0) |-> $stable(bit_count) || $past(bit_valid));
endmodule

bind mw_monitor mw_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .bit_valid        (bit_valid),
    .bit_si           (bit_si),
    .bit_is_start     (bit_is_start),
    .window_done      (window_done),
    .bit_count        (bit_count),
    .status_valid     (status_valid),
    .err_no_start_bit (err_no_start_bit)
);

// File: tb/test_mw_monitor.sv
module test_mw_monitor;
    localparam int CW   = 3;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_in = 1'b0, sk_in = 1'b0, si_in = 1'b0, so_in = 1'b0;
    logic bit_valid, bit_si, bit_so, bit_is_start, window_done;
    logic [CW-1:0] bit_count;
    logic status_valid, status_ready, err_sk_high_at_start, err_no_start_bit;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    mw_monitor #(.CNT_W(CW)) i_mw_monitor (
        .clk(clk), .rst_n(rst_n), .cs_in(cs_in), .sk_in(sk_in), .si_in(si_in),
        .so_in(so_in), .bit_valid(bit_valid), .bit_si(bit_si), .bit_so(bit_so),
        .bit_is_start(bit_is_start), .window_done(window_done), .bit_count(bit_count),
        .status_valid(status_valid), .status_ready(status_ready),
        .err_sk_high_at_start(err_sk_high_at_start), .err_no_start_bit(err_no_start_bit)
    );

    // Collector of records and done pulses, sampled away from the active edge.
    int nrec = 0;
    int done_cnt = 0;
    int done_val = 0;
    int done_with_rec = 0;
    logic rec_si [64];
    logic rec_so [64];
    logic rec_st [64];

    always @(negedge clk) begin
        if (rst_n && bit_valid) begin
            if (nrec < 64) begin
                rec_si[nrec] = bit_si;
                rec_so[nrec] = bit_so;
                rec_st[nrec] = bit_is_start;
            end
            nrec++;
        end
        if (rst_n && window_done) begin
            done_cnt++;
            done_val = int'(bit_count);
            done_with_rec = int'(bit_valid);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One bit: data-in set, clock rises, data-out set, clock falls.
    task automatic send_bit(input logic vi, input logic vo);
        si_in = vi; cyc(2);
        sk_in = 1'b1; cyc(2);
        so_in = vo; cyc(2);
        sk_in = 1'b0; cyc(2);
    endtask

    // Transfer window; mode 0 normal end, 1 clock and select fall together,
    // 2 select falls with the clock high after the last rising edge.
    task automatic xfer(input int n, input int sp, input int op, input int mode,
                        input bit sk_hi, input string tag);
        int base_done;
        int exp_n;
        base_done = done_cnt;
        nrec = 0;
        if (sk_hi) begin sk_in = 1'b1; cyc(2); end
        cs_in = 1'b1; cyc(4);
        if (sk_hi) begin so_in = 1'b1; sk_in = 1'b0; cyc(4); end
        for (int k = 0; k < n; k++) begin
            if (k == n - 1 && mode != 0) begin
                si_in = sp[k]; cyc(2);
                sk_in = 1'b1; cyc(2);
                if (mode == 1) begin
                    so_in = ~op[k]; cyc(2);
                    so_in = op[k]; sk_in = 1'b0; cs_in = 1'b0; cyc(2);
                end else begin
                    cs_in = 1'b0; cyc(2);
                    sk_in = 1'b0;
                end
            end else begin
                send_bit(sp[k], op[k]);
            end
        end
        if (mode == 0) cs_in = 1'b0;
        cyc(8);
        si_in = 1'b0; so_in = 1'b0;
        exp_n = (mode == 2) ? n - 1 : n;
        chk({tag, " R5/R6 record count"}, nrec, exp_n);
        for (int k = 0; k < exp_n && k < 64; k++) begin
            chk({tag, " R3 si"}, int'(rec_si[k]), sp[k]);
            chk({tag, " R3/R11 so"}, int'(rec_so[k]), op[k]);
            chk({tag, " R4 start flag"}, int'(rec_st[k]), (k == 0) ? 1 : 0);
        end
        chk({tag, " R5 one done pulse"}, done_cnt - base_done, 1);
        chk({tag, " R10 count"}, done_val, (exp_n > CMAX) ? CMAX : exp_n);
        if (mode != 2) chk({tag, " R5 done with last record"}, done_with_rec, 1);
        chk({tag, " R7 not status"}, int'(status_valid), 0);
        chk({tag, " R8 no err"}, int'(err_no_start_bit), 0);
        chk({tag, " R9 sk flag"}, int'(err_sk_high_at_start), int'(sk_hi));
    endtask

    bit finished = 1'b0;

    initial begin
        cyc(3);
        // R1: reset state.
        chk("R1 bit_valid", int'(bit_valid), 0);
        chk("R1 window_done", int'(window_done), 0);
        chk("R1 bit_count", int'(bit_count), 0);
        chk("R1 status", int'({status_valid, status_ready}), 0);
        chk("R1 errors", int'({err_sk_high_at_start, err_no_start_bit}), 0);
        rst_n = 1'b1;
        cyc(4);
        chk("R1 idle after release", int'(status_valid), 0);

        // R3 R4 R5: sweep of all data-in patterns after the start bit, lengths 1..6.
        for (int n = 1; n <= 6; n++) begin
            for (int p = 0; p < (1 << (n - 1)); p++) begin
                int sp;
                int op;
                sp = (p << 1) | 1;
                op = (sp * 5 + n) & ((1 << n) - 1);
                xfer(n, sp, op, 0, 1'b0, "sweep");
            end
        end

        // R11: clock and select fall in the same sample.
        xfer(3, 3'b101, 3'b100, 1, 1'b0, "R11 same-sample end");
        xfer(4, 4'b1111, 4'b0111, 1, 1'b0, "R11 same-sample end b");
        // R6: select falls while the clock is high.
        xfer(4, 4'b1011, 4'b0110, 2, 1'b0, "R6 drop last");
        // R9: clock high at window start, then decoded normally.
        xfer(3, 3'b011, 3'b010, 0, 1'b1, "R9 sk high");
        // R2: next window clears the flag.
        xfer(2, 2'b01, 2'b10, 0, 1'b0, "R2 clear");
        // R10: saturation at the count limit.
        xfer(10, 10'b1010110101, 10'b0110011001, 0, 1'b0, "R10 saturate");

        // R7: status check without any clock edge.
        nrec = 0;
        so_in = 1'b0; cs_in = 1'b1; cyc(6);
        chk("R7 status valid open", int'(status_valid), 1);
        chk("R7 busy", int'(status_ready), 0);
        so_in = 1'b1; cyc(6);
        chk("R7 ready", int'(status_ready), 1);
        so_in = 1'b0; cyc(6);
        chk("R7 busy again", int'(status_ready), 0);
        so_in = 1'b1; cyc(6);
        cs_in = 1'b0; cyc(6);
        so_in = 1'b0; cyc(6);
        chk("R7 held ready", int'(status_ready), 1);
        chk("R7 held valid", int'(status_valid), 1);
        chk("R7 no records", nrec, 0);
        chk("R8 no error without clock", int'(err_no_start_bit), 0);
        chk("R10 status count", done_val, 0);

        // R8: clocked window with data-in low at the first rising edge.
        nrec = 0;
        cs_in = 1'b1; cyc(4);
        send_bit(1'b0, 1'b1);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b1);
        chk("R8 flag", int'(err_no_start_bit), 1);
        chk("R8 status", int'(status_valid), 1);
        chk("R7 follows so", int'(status_ready), 1);
        cs_in = 1'b0; cyc(8);
        chk("R8 no records", nrec, 0);
        chk("R2 flag cleared next window pre", int'(err_no_start_bit), 1);
        cs_in = 1'b1; cyc(6);
        chk("R2 flag cleared on open", int'(err_no_start_bit), 0);
        chk("R2 count cleared on open", int'(bit_count), 0);
        cs_in = 1'b0; cyc(8);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule